// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Unit

This block watches a running calendar clock and raises interrupts when the time reaches one of two programmed alarm points. Each alarm holds four BCD fields: seconds, minutes, hours and day of week. Bit 7 of every alarm field is a "don't care" flag. When that bit is set, the field takes no part in the comparison. By masking more or fewer fields, an alarm can fire once a second, once a minute, once an hour, once a day or once a week.

The comparison runs only in the cycle where the update strobe is high, which is once per clock second. A match sets a sticky per-alarm flag. The flag stays set until a clear pulse arrives. Two active-low interrupt lines carry the flags. A routing bit selects between two arrangements:
- each alarm drives its own line, or
- both alarms share line 0.

A per-alarm enable gates each flag before it reaches a line. The time fields, the strobe and the register writes are control-style signals with no flow control: a write takes effect in the cycle it is presented, so no valid/ready handshake is used.

Top module: `tod_alarm_unit`

## Requirements
- R1: After reset, both flags are 0, both interrupt lines are high, all alarm fields are 00h and the control bits are 0.
- R2: An alarm field whose bit 7 is 1 is ignored in the comparison. A field whose bit 7 is 0 matches when its bits 6:0 equal bits 6:0 of the corresponding time field.
- R3: In a cycle where `tick` is 1, an alarm whose unmasked fields all match sets its flag at that clock edge. This covers every mask pattern, including all-masked (fires every second) and none-masked (weekly).
- R4: When `tick` is 0, no flag is set, even while the time matches. A flag cleared during a held match stays 0 until the next `tick`.
- R5: A flag stays set until its clear input (`clr0`/`clr1`) is pulsed. If a clear and a setting match fall in the same cycle, the flag ends up set.
- R6: With the routing bit at 1, `irq0_n` is the inverse of (flag0 AND en0), and `irq1_n` is the inverse of (flag1 AND en1).
- R7: With the routing bit at 0, `irq0_n` is low when (flag0 AND en0) OR (flag1 AND en1), and `irq1_n` stays high.
- R8: A flag sets whatever its enable is. A disabled flag never pulls a line low.
- R9: The hours comparison uses bits 6:0 in full, including the 12/24 select bit and the PM bit. For example, alarm 67h (7 PM in 12-hour mode) does not match time 07h or 47h.
- R10: A write with `wr_en` high stores `wr_data` into the field at `wr_addr`. Indices 0 to 3 are alarm 0 seconds, minutes, hours and day. Indices 4 to 7 are the same fields of alarm 1. No other field changes.
- R11: A control write (`ctl_we` high) loads `ctl_data`: bit 0 is en0, bit 1 is en1 and bit 2 is the routing bit. The new values take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Once-per-second update strobe |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, same encoding as the alarm hours field |
| cur_day | input | 8 | Current day of week |
| wr_en | input | 1 | Alarm field write strobe |
| wr_addr | input | 3 | Alarm field index |
| wr_data | input | 8 | Alarm field value; bit 7 is the mask |
| ctl_we | input | 1 | Control write strobe |
| ctl_data | input | 3 | {route, en1, en0} |
| clr0 | input | 1 | Clear pulse for flag 0 |
| clr1 | input | 1 | Clear pulse for flag 1 |
| flag0 | output | 1 | Alarm 0 sticky flag |
| flag1 | output | 1 | Alarm 1 sticky flag |
| irq0_n | output | 1 | Interrupt line 0, active low |
| irq1_n | output | 1 | Interrupt line 1, active low |

## Verification
The assertions check the following on every cycle:
- a flag never sets without a strobe;
- a flag holds until it is cleared;
- a strobed match sets the flag;
- line 1 stays idle in merged routing;
- a low line always has an enabled, set flag behind it.

Only the bench's scenarios can show the rest:
- the arithmetic of the comparison across all 16 mask patterns and all 16 match/mismatch combinations;
- the full hours encoding;
- the field write map;
- same-cycle clear-versus-set ordering;
- the exact line levels over every routing and enable combination.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
  localparam int FIELD_W  = 8;
  localparam int MASK_BIT = 7;
  localparam int NFIELD   = 4;   // sec, min, hour, day
  localparam int NALARM   = 2;
  localparam int AW       = $clog2(NFIELD * NALARM);
  typedef logic [FIELD_W-1:0] field_t;
  typedef field_t [NFIELD-1:0] fieldset_t;
  typedef struct packed {
    logic route;
    logic en1;
    logic en0;
  } ctl_t;
endpackage

// File: rtl/alarm_field_regs.sv
module alarm_field_regs
  import tod_alarm_pkg::*;
#(
  parameter int BASE = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  field_t        wr_data,
  output fieldset_t     fields
);
  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    localparam logic [AW-1:0] IDX = AW'(BASE + i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       fields[i] <= '0;
      else if (wr_en && wr_addr == IDX) fields[i] <= wr_data;
    end
  end
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import tod_alarm_pkg::*;
(
  input  fieldset_t alarm,
  input  fieldset_t now,
  output logic      hit
);
  logic [NFIELD-1:0] ok;
  for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
    assign ok[i] = alarm[i][MASK_BIT] ||
                   (alarm[i][MASK_BIT-1:0] == now[i][MASK_BIT-1:0]);
  end
  assign hit = &ok;
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hit,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           flag <= 1'b0;
    else if (tick && hit) flag <= 1'b1;   // set wins over clear
    else if (clr)         flag <= 1'b0;
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import tod_alarm_pkg::*;
(
  input  ctl_t              ctl,
  input  logic [NALARM-1:0] flags,
  output logic              irq0_n,
  output logic              irq1_n
);
  logic a0, a1;
  assign a0 = flags[0] && ctl.en0;
  assign a1 = flags[1] && ctl.en1;
  always_comb begin
    if (ctl.route) begin
      irq0_n = !a0;
      irq1_n = !a1;
    end else begin
      irq0_n = !(a0 || a1);
      irq1_n = 1'b1;
    end
  end
endmodule

// File: rtl/tod_alarm_unit.sv
module tod_alarm_unit
  import tod_alarm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [7:0] cur_sec,
  input  logic [7:0] cur_min,
  input  logic [7:0] cur_hour,
  input  logic [7:0] cur_day,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       ctl_we,
  input  logic [2:0] ctl_data,
  input  logic       clr0,
  input  logic       clr1,
  output logic       flag0,
  output logic       flag1,
  output logic       irq0_n,
  output logic       irq1_n
);
  fieldset_t         now;
  ctl_t              ctl_q;
  logic [NALARM-1:0] hit_w;
  logic [NALARM-1:0] flag_w;
  logic [NALARM-1:0] clr_w;

  assign now   = {cur_day, cur_hour, cur_min, cur_sec};
  assign clr_w = {clr1, clr0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_t'(ctl_data);
  end

  for (genvar a = 0; a < NALARM; a++) begin : g_alarm
    fieldset_t set_q;
    alarm_field_regs #(.BASE(a * NFIELD)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .fields(set_q)
    );
    alarm_match u_match (.alarm(set_q), .now(now), .hit(hit_w[a]));
    alarm_flag u_flag (
      .clk(clk), .rst_n(rst_n), .tick(tick), .hit(hit_w[a]),
      .clr(clr_w[a]), .flag(flag_w[a])
    );
  end

  irq_router u_route (.ctl(ctl_q), .flags(flag_w), .irq0_n(irq0_n), .irq1_n(irq1_n));

  assign flag0 = flag_w[0];
  assign flag1 = flag_w[1];
endmodule

// File: rtl/tod_alarm_chk.sv
module tod_alarm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       clr0,
  input logic       clr1,
  input logic       flag0,
  input logic       flag1,
  input logic       irq0_n,
  input logic       irq1_n,
  input logic [1:0] hit,
  input logic [2:0] ctl
);
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!flag0 && !flag1));
  a_r4_no_set_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag0 && !tick) |=> !flag0);
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag1 && !clr1) |=> flag1);
  a_r3_set_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hit[0]) |=> flag0);
  a_r7_merged_line1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[2] |-> irq1_n);
  a_r8_low_needs_enabled_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !irq0_n |-> ((flag0 && ctl[0]) || (flag1 && ctl[1])));
  a_r6_line1_source: assert property (@(posedge clk) disable iff (!rst_n)
    !irq1_n |-> (flag1 && ctl[1] && ctl[2]));
  logic unused_ok;
  assign unused_ok = clr0;
endmodule

bind tod_alarm_unit tod_alarm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .clr0(clr0), .clr1(clr1),
  .flag0(flag0), .flag1(flag1), .irq0_n(irq0_n), .irq1_n(irq1_n),
  .hit(hit_w), .ctl(ctl_q)
);

// File: tb/tod_alarm_unit_tb.sv
module tod_alarm_unit_tb;
  logic clk = 0, rst_n = 0, tick = 0;
  logic [7:0] cur_sec = 0, cur_min = 0, cur_hour = 0, cur_day = 0;
  logic wr_en = 0, ctl_we = 0, clr0 = 0, clr1 = 0;
  logic [2:0] wr_addr = 0, ctl_data = 0;
  logic [7:0] wr_data = 0;
  logic flag0, flag1, irq0_n, irq1_n;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tod_alarm_unit u_dut (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic ctl(input logic [2:0] d);
    @(negedge clk); ctl_we = 1; ctl_data = d;
    @(negedge clk); ctl_we = 0;
  endtask
  task automatic pulse_tick;
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask
  task automatic clear_both;
    @(negedge clk); clr0 = 1; clr1 = 1;
    @(negedge clk); clr0 = 0; clr1 = 0;
  endtask
  task automatic set_time(input logic [7:0] s, m, h, d);
    cur_sec = s; cur_min = m; cur_hour = h; cur_day = d;
  endtask
  task automatic all_masked;
    for (int i = 0; i < 8; i++) wr(3'(i), 8'h80);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] base [4];
    base[0] = 8'h25; base[1] = 8'h41; base[2] = 8'h13; base[3] = 8'h05;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 flag0", {7'b0, flag0}, 0);
    check("R1 flag1", {7'b0, flag1}, 0);
    check("R1 irq0_n", {7'b0, irq0_n}, 1);
    check("R1 irq1_n", {7'b0, irq1_n}, 1);
    rst_n = 1;
    @(negedge clk);
    // R1 fields reset to 00h: time 00 everywhere matches alarm 0 (all fields zero)
    set_time(0, 0, 0, 0); pulse_tick;
    check("R1 zero fields match", {6'b0, flag1, flag0}, 8'h03);
    clear_both;

    // R2/R3 sweep: mask pattern m x match pattern q, both alarms
    for (int m = 0; m < 16; m++) begin
      for (int f = 0; f < 4; f++) begin
        wr(3'(f), base[f] | (m[f] ? 8'h80 : 8'h00));
        wr(3'(f + 4), base[f] | (m[f] ? 8'h80 : 8'h00));
      end
      for (int q = 0; q < 16; q++) begin
        logic [7:0] t [4];
        logic exp;
        for (int f = 0; f < 4; f++) t[f] = q[f] ? base[f] : base[f] + 8'h01;
        exp = &(4'(m) | 4'(q));
        set_time(t[0], t[1], t[2], t[3]);
        clear_both;
        pulse_tick;
        check("R2/R3 alarm0 mask sweep", {7'b0, flag0}, {7'b0, exp});
        check("R3 alarm1 mask sweep", {7'b0, flag1}, {7'b0, exp});
      end
    end
    clear_both;

    // R9 hours full encoding
    all_masked; wr(3'd2, 8'h67);
    set_time(0, 0, 8'h07, 1); pulse_tick;
    check("R9 67h vs 07h", {7'b0, flag0}, 0);
    cur_hour = 8'h47; pulse_tick;
    check("R9 67h vs 47h", {7'b0, flag0}, 0);
    cur_hour = 8'h67; pulse_tick;
    check("R9 67h vs 67h", {7'b0, flag0}, 1);
    clear_both;

    // R10 write map: only alarm1 minutes unmatchable
    all_masked; wr(3'd5, 8'h59); set_time(0, 0, 0, 0); pulse_tick;
    check("R10 alarm0 unaffected", {7'b0, flag0}, 1);
    check("R10 alarm1 minutes", {7'b0, flag1}, 0);
    clear_both;

    // R4 no tick, no set; clear during held match stays clear
    all_masked;
    repeat (4) @(negedge clk);
    check("R4 no tick", {6'b0, flag1, flag0}, 0);
    pulse_tick;
    check("R4 tick sets", {6'b0, flag1, flag0}, 8'h03);
    clear_both;
    repeat (3) @(negedge clk);
    check("R4 cleared held match", {6'b0, flag1, flag0}, 0);

    // R5 sticky and set-over-clear
    pulse_tick;
    repeat (5) @(negedge clk);
    check("R5 sticky", {6'b0, flag1, flag0}, 8'h03);
    @(negedge clk); tick = 1; clr0 = 1; clr1 = 1;
    @(negedge clk); tick = 0; clr0 = 0; clr1 = 0;
    check("R5 set wins", {6'b0, flag1, flag0}, 8'h03);

    // R6/R7/R8/R11 routing sweep: ctl x flag states
    for (int c = 0; c < 8; c++) begin
      ctl(3'(c));
      for (int fs = 0; fs < 4; fs++) begin
        logic a0, a1, e0, e1;
        clear_both;
        all_masked;
        if (!fs[0]) wr(3'd0, 8'h7F);
        if (!fs[1]) wr(3'd4, 8'h7F);
        set_time(0, 0, 0, 0); pulse_tick;
        a0 = fs[0] && c[0]; a1 = fs[1] && c[1];
        e0 = c[2] ? !a0 : !(a0 || a1);
        e1 = c[2] ? !a1 : 1'b1;
        check("R8 flags set regardless of enable", {6'b0, flag1, flag0}, 8'(fs));
        check(c[2] ? "R6/R11 irq0_n" : "R7/R11 irq0_n", {7'b0, irq0_n}, {7'b0, e0});
        check(c[2] ? "R6/R11 irq1_n" : "R7/R11 irq1_n", {7'b0, irq1_n}, {7'b0, e1});
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule